// File: doc/BRIEF.md
# Triggered Multichannel Hit Latency Pipeline

This block holds the digitized hit bits of a set of detector channels long enough for a slow trigger decision to catch up with them. On every clock each channel pushes its current hit bit into its own fixed-length shift register. The last stage of each register therefore shows the hit the channel saw a fixed number of clocks earlier.

When a trigger is accepted, the control unit opens a gate over the delayed stream for a run-time number of clocks. A channel whose delayed bit is high on any cycle of that gate is flagged. When the gate closes, the flags are copied into a parallel output pattern and a valid strobe is raised. The strobe is held until the consumer accepts it.

The delay lines never stop shifting, so hits that arrive while a gate or readout is in progress still reach the next window. Triggers that arrive while the block is busy are dropped. The output is a plain per-channel hit pattern with no detector-specific framing.

Top module: `hit_latency_pipe`

## Requirements
- R1: Each channel's delay is DEPTH (default 100) clocks. For a trigger sampled at rising edge T with gate length L, a hit bit sampled at edge h is flagged exactly when T-DEPTH+1 <= h <= T-DEPTH+L.
- R2: The gate length L equals the value on `gate_len` (4 bits) sampled with the trigger, from 1 to 15. A value of 0 acts as 1.
- R3: `out_valid` rises on edge T+L, which is exactly L clocks after the trigger edge, and not earlier. `out_pattern` bit c then holds the flag of channel c.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pattern` stay unchanged. An edge on which both are high drops `out_valid` and clears the flags, so the next window starts empty.
- R5: `busy` is high from the clock after an accepted trigger until the edge that accepts the readout, and low otherwise.
- R6: A trigger arriving while `busy` is high changes neither the gate timing nor the pattern.
- R7: The delay lines keep shifting during the gate and the readout. Hits entering during a busy period are reported by a later window that covers them.
- R8: The asynchronous active-low reset clears every delay stage, the flags, `busy` and `out_valid`. Hits seen before reset are never reported.
- R9: Channels are independent. A hit on one channel never sets another channel's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hit_in | input | N_CH | One hit bit per channel, sampled every clock |
| trig | input | 1 | Trigger request, one clock |
| gate_len | input | GATE_W | Gate length in clocks (0 acts as 1) |
| out_ready | input | 1 | Consumer accepts the pattern |
| busy | output | 1 | Gate or readout in progress |
| out_valid | output | 1 | Pattern is valid |
| out_pattern | output | N_CH | Per-channel hit flags |

## Verification
The main sweep uses every gate length from 1 to 15. For each length, a single hit is placed one clock before the window, at every position inside it, and one clock after it, on a channel that rotates per trial. This separates an off-by-one in the delay from an off-by-one in the gate length. A staircase pattern that places each channel at a different offset shows that channels do not leak into one another. Sparse random hits with back-to-back triggers, held readouts and triggers injected during busy show that the delay lines keep shifting through busy periods and that stray triggers are dropped. A burst of hits followed by a reset shows that nothing from before reset is reported.

// File: rtl/hlp_pkg.sv
package hlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_READ = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/hlp_delay_line.sv
module hlp_delay_line #(
  parameter int DEPTH = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tap
);
  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign tap = sr_q[DEPTH-1];
endmodule

// File: rtl/hlp_ctrl.sv
module hlp_ctrl
  import hlp_pkg::*;
#(
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [GATE_W-1:0] gate_len,
  input  logic              out_ready,
  output logic              gate_on,
  output logic              gate_last,
  output logic              accept,
  output logic              busy,
  output logic              out_valid
);
  ctl_state_t        st_q, st_d;
  logic [GATE_W-1:0] cnt_q, cnt_d;
  logic [GATE_W-1:0] eff_len;

  assign eff_len = (gate_len == '0) ? GATE_W'(1) : gate_len;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (trig) begin
          st_d  = ST_GATE;
          cnt_d = eff_len;
        end
      end
      ST_GATE: begin
        if (cnt_q == GATE_W'(1)) st_d = ST_READ;
        else                     cnt_d = cnt_q - GATE_W'(1);
      end
      ST_READ: begin
        if (out_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign gate_on   = (st_q == ST_GATE);
  assign gate_last = gate_on && (cnt_q == GATE_W'(1));
  assign out_valid = (st_q == ST_READ);
  assign accept    = out_valid && out_ready;
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/hlp_hit_accum.sv
module hlp_hit_accum #(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] tap_vec,
  input  logic            gate_on,
  input  logic            gate_last,
  input  logic            clear,
  output logic [N_CH-1:0] pattern
);
  logic [N_CH-1:0] flag_q, flag_d;
  logic            flag_en;
  logic [N_CH-1:0] pat_q;
  logic            pat_en;

  always_comb begin
    flag_en = clear || gate_on;
    flag_d  = clear ? '0 : (flag_q | tap_vec);
    pat_en  = gate_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= '0;
    else if (pat_en) pat_q <= flag_q | tap_vec;
  end

  assign pattern = pat_q;
endmodule

// File: rtl/hit_latency_pipe.sv
module hit_latency_pipe #(
  parameter int N_CH   = 16,
  parameter int DEPTH  = 100,
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hit_in,
  input  logic              trig,
  input  logic [GATE_W-1:0] gate_len,
  input  logic              out_ready,
  output logic              busy,
  output logic              out_valid,
  output logic [N_CH-1:0]   out_pattern
);
  logic [N_CH-1:0] tap_vec;
  logic            gate_on, gate_last, accept;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    hlp_delay_line #(.DEPTH(DEPTH)) u_dl (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (hit_in[c]),
      .tap  (tap_vec[c])
    );
  end

  hlp_ctrl #(.GATE_W(GATE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .gate_len (gate_len),
    .out_ready(out_ready),
    .gate_on  (gate_on),
    .gate_last(gate_last),
    .accept   (accept),
    .busy     (busy),
    .out_valid(out_valid)
  );

  hlp_hit_accum #(.N_CH(N_CH)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap_vec  (tap_vec),
    .gate_on  (gate_on),
    .gate_last(gate_last),
    .clear    (accept),
    .pattern  (out_pattern)
  );
endmodule

// File: rtl/hlp_checker.sv
module hlp_checker #(
  parameter int N_CH   = 16,
  parameter int GATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic [GATE_W-1:0] gate_len,
  input logic              out_ready,
  input logic              busy,
  input logic              out_valid,
  input logic [N_CH-1:0]   out_pattern
);
  logic [7:0] cyc_q;
  logic [7:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      len_q <= '0;
    end else if (!busy && trig) begin
      cyc_q <= 8'd1;
      len_q <= (gate_len == '0) ? 8'd1 : 8'(gate_len);
    end else if (busy && !out_valid) begin
      cyc_q <= cyc_q + 8'd1;
    end
  end

  // R5: out_valid only while busy
  p_valid_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  // R5: an accepted trigger raises busy, no early valid
  p_trig_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig) |=> (busy && !out_valid));
  // R5 / R6: busy persists until the readout is accepted
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(out_valid && out_ready)) |=> busy);
  // R4: pattern held while waiting
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pattern)));
  // R4: acceptance ends the readout
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && !busy));
  // R3: valid rises exactly gate length clocks after trigger
  p_gate_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (cyc_q == len_q + 8'd1));
endmodule

bind hit_latency_pipe hlp_checker #(.N_CH(N_CH), .GATE_W(GATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig       (trig),
  .gate_len   (gate_len),
  .out_ready  (out_ready),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_pattern(out_pattern)
);

// File: tb/sim_hit_latency_pipe.sv
module sim_hit_latency_pipe;
  localparam int N_CH  = 16;
  localparam int DEPTH = 100;
  localparam int GW    = 4;
  localparam int HMAX  = 65536;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N_CH-1:0] hit_in;
  logic            trig;
  logic [GW-1:0]   gate_len;
  logic            out_ready;
  logic            busy, out_valid;
  logic [N_CH-1:0] out_pattern;

  int checks = 0;
  int failures = 0;
  int n = 0;
  bit done = 0;
  logic [N_CH-1:0] stim [HMAX];
  logic [N_CH-1:0] hist [HMAX];

  always #2.5 clk = ~clk;

  hit_latency_pipe #(.N_CH(N_CH), .DEPTH(DEPTH), .GATE_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .trig(trig),
    .gate_len(gate_len), .out_ready(out_ready), .busy(busy),
    .out_valid(out_valid), .out_pattern(out_pattern));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", tag, act, exp, n);
    end
  endtask

  task automatic step(input logic [N_CH-1:0] h, input logic t);
    hit_in = h;
    trig   = t;
    @(posedge clk);
    hist[n] = rst_n ? h : '0;
    n++;
    @(negedge clk);
  endtask

  function automatic logic [N_CH-1:0] window(input int t_edge, input int len);
    logic [N_CH-1:0] acc = '0;
    for (int h = t_edge - DEPTH + 1; h <= t_edge - DEPTH + len; h++)
      if (h >= 0) acc |= hist[h];
    return acc;
  endfunction

  task automatic trial(input int lset, input int gap, input int hold,
                       input logic extra, input string tag);
    int len;
    int t_edge;
    logic [N_CH-1:0] exp;
    len = (lset == 0) ? 1 : lset;
    gate_len  = GW'(lset);
    out_ready = 1'b0;
    chk("R5 idle busy", 32'(busy), 0);
    repeat (gap - 1) step(stim[n], 1'b0);
    t_edge = n;
    step(stim[n], 1'b1);
    for (int k = 1; k <= len; k++) begin
      step(stim[n], extra);
      chk("R3 valid timing", 32'(out_valid), 32'(k == len));
      chk("R5 busy in gate", 32'(busy), 1);
    end
    exp = window(t_edge, len);
    chk(tag, 32'(out_pattern), 32'(exp));
    for (int k = 0; k < hold; k++) begin
      step(stim[n], extra);
      chk("R4 valid held", 32'(out_valid), 1);
      chk("R4 pattern held", 32'(out_pattern), 32'(exp));
    end
    out_ready = 1'b1;
    step(stim[n], 1'b0);
    out_ready = 1'b0;
    chk("R4 accept drops valid", 32'(out_valid), 0);
    chk("R5 accept drops busy", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t_edge, w, ch;
    for (int i = 0; i < HMAX; i++) begin stim[i] = '0; hist[i] = '0; end
    hit_in = '0; trig = 1'b0; gate_len = GW'(1); out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) step('0, 1'b0);
    chk("R8 reset busy", 32'(busy), 0);
    chk("R8 reset valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) step('0, 1'b0);

    // R8: hits before a reset must vanish
    repeat (60) step('1, 1'b0);
    rst_n = 1'b0;
    repeat (2) step('1, 1'b0);
    chk("R8 reset mid-run valid", 32'(out_valid), 0);
    for (int i = 0; i < n; i++) hist[i] = '0;
    rst_n = 1'b1;
    trial(15, 40, 0, 1'b0, "R8 pre-reset hits");

    // R1 / R2: single-hit offset sweep over all gate lengths
    for (int len = 1; len <= 15; len++) begin
      for (int d = -1; d <= len; d++) begin
        t_edge = n + DEPTH + 1;
        w = t_edge - DEPTH + 1;
        ch = (len * 3 + d + 1) % N_CH;
        stim[w + d] = N_CH'(1) << ch;
        trial(len, DEPTH + 2, 0, 1'b0, "R1 window offset");
      end
    end

    // R2: gate_len 0 acts as 1
    t_edge = n + DEPTH + 1;
    w = t_edge - DEPTH + 1;
    stim[w]     = 16'h0001;
    stim[w + 1] = 16'h0100;
    trial(0, DEPTH + 2, 0, 1'b0, "R2 zero length");

    // R9: staircase, channel c at offset c-2, gate of 10
    t_edge = n + DEPTH + 3;
    w = t_edge - DEPTH + 1;
    for (int c = 0; c < N_CH; c++) stim[w + c - 2] = stim[w + c - 2] | (N_CH'(1) << c);
    trial(10, DEPTH + 4, 2, 1'b0, "R9 channel isolation");

    // R6 / R7: sparse random hits, back-to-back triggers
    for (int i = n; i < n + 6000; i++) begin
      logic [31:0] r;
      r = $urandom & $urandom & $urandom & $urandom;
      stim[i] = r[N_CH-1:0];
    end
    for (int i = 0; i < 30; i++) begin
      if (i % 2 == 1) trial(1 + (i % 15), 1 + (i % 3), i % 4, 1'b1, "R6 stray triggers");
      else            trial(1 + ((i * 7) % 15), 1, i % 3, 1'b0, "R7 shift during busy");
    end
    for (int i = 0; i < 12; i++) trial(15, 40 + i * 5, 3, 1'b1, "R7 late window");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule